// File: doc/BRIEF.md
# Scroll Latch Write Port

This block sits between the CPU register interface and the background address logic of a tile-based video generator. It owns the 15-bit staging address, the 3-bit fine horizontal pixel offset, and the single toggle bit that decides whether a byte is the first or the second half of a two-byte write. Each clock it accepts at most one register access. An access has a valid pulse, a 2-bit port select, a read/write flag and a data byte. The block updates its state as the addressed port requires.

There are four ports. A control port sets the nametable select bits. A status port clears the toggle when it is read. A scroll port takes the horizontal and then the vertical scroll. An address port takes the high and then the low byte of a video address. The scroll port and the address port share the one toggle, but each spreads its bytes over the staging address in a different way. The second byte written to the address port raises a one-cycle load strobe. During that cycle the block presents the completed staging address, so the external current-address counter can take it.

Top module: `scroll_latch_port`

## Requirements
- R1: While rst_n is low, the staging address, fine offset and toggle all read zero, and the load strobe is low.
- R2: Port select 0 with the write flag high is the control port. It copies data[1:0] into staging bits 11:10, leaves every other staging bit, the fine offset and the toggle unchanged, and its result is visible in the cycle after the access.
- R3: Port select 1 with the write flag low is the status read. It clears the toggle and changes neither the staging address nor the fine offset.
- R4: Port select 2 written with the toggle at 0 puts data[7:3] into staging bits 4:0 and data[2:0] into the fine offset, then sets the toggle.
- R5: Port select 2 written with the toggle at 1 puts data[2:0] into staging bits 14:12 and data[7:3] into staging bits 9:5, then clears the toggle. The fine offset is left unchanged.
- R6: Port select 3 written with the toggle at 0 puts data[5:0] into staging bits 13:8, forces staging bit 14 to 0, and sets the toggle.
- R7: Port select 3 written with the toggle at 1 puts data[7:0] into staging bits 7:0 and clears the toggle. In the next cycle the load strobe is high for exactly one cycle, and the load value equals the updated staging address.
- R8: The scroll and address ports flip the same toggle, so writes that alternate between them also alternate between first-byte and second-byte behaviour.
- R9: An idle cycle has no effect on the state. So has a read of any port other than the status port, and so has a write to the status port.
- R10: From the reset state, the sequence control←0x00, scroll←0x7D, scroll←0x5E, address←0x3D, address←0xF0 ends with staging address 0x3DF0, load value 0x3DF0, fine offset 3'b101 and the toggle at 0.
- R11: The load strobe is raised only in the cycle after a second-byte address write, and the fine offset changes only after a first-byte scroll write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A register access is present this cycle |
| acc_sel | input | 2 | Port select: 0 control, 1 status, 2 scroll, 3 address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_data | input | 8 | Write data byte |
| stage_addr | output | 15 | Staging address register |
| fine_x | output | 3 | Fine horizontal pixel offset |
| phase | output | 1 | Write toggle: 0 means the next byte is the first byte |
| load_stb | output | 1 | One-cycle strobe to load the current address |
| load_addr | output | 15 | Value to load while load_stb is high |

## Verification
The bench mixes scroll and address writes so that the toggle is shared across both ports. A design with a separate toggle per port would apply the wrong byte mapping and would fail the mixed sequences. It writes 0xFF to the first address byte on top of a staging address whose bit 14 is set, to expose a design that does not force bit 14 to zero. It checks that the strobe lasts exactly one cycle and carries the updated staging address, so a strobe that is missing or held high, or a load value that lags by one byte, is caught. It also sends reads to non-status ports and a write to the status port, to catch a decoder that ignores the read/write flag.

// File: rtl/scroll_latch_pkg.sv
package scroll_latch_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int FINE_W = 3;
  localparam int SEL_W  = 2;

  // Field positions inside the staging address
  localparam int CX_LO = 0;
  localparam int CX_HI = 4;
  localparam int CY_LO = 5;
  localparam int CY_HI = 9;
  localparam int NT_LO = 10;
  localparam int NT_HI = 11;
  localparam int FY_LO = 12;
  localparam int FY_HI = ADDR_W - 1;
  localparam int HI_BYTE_W = 6;
  localparam int TOP_BIT = ADDR_W - 1;

  typedef enum logic [SEL_W-1:0] {
    PORT_CTRL = 2'd0,
    PORT_STAT = 2'd1,
    PORT_SCRL = 2'd2,
    PORT_ADDR = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic ctrl_wr;
    logic stat_rd;
    logic scrl_wr;
    logic addr_wr;
  } acc_kind_t;
endpackage

// File: rtl/scroll_access_decode.sv
module scroll_access_decode
  import scroll_latch_pkg::*;
(
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  input  logic             write,
  output acc_kind_t        kind
);
  always_comb begin
    kind = '0;
    if (valid) begin
      unique case (port_sel_e'(sel))
        PORT_CTRL: kind.ctrl_wr = write;
        PORT_STAT: kind.stat_rd = ~write;
        PORT_SCRL: kind.scrl_wr = write;
        PORT_ADDR: kind.addr_wr = write;
        default:   kind = '0;
      endcase
    end
  end
endmodule

// File: rtl/scroll_stage_reg.sv
module scroll_stage_reg
  import scroll_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic              phase,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] stage_q
);
  logic [ADDR_W-1:0] stage_nx;
  logic              stage_en;

  always_comb begin
    stage_nx = stage_q;
    stage_en = kind.ctrl_wr | kind.scrl_wr | kind.addr_wr;
    if (kind.ctrl_wr)
      stage_nx[NT_HI:NT_LO] = data[1:0];
    if (kind.scrl_wr && !phase)
      stage_nx[CX_HI:CX_LO] = data[DATA_W-1:FINE_W];
    if (kind.scrl_wr && phase) begin
      stage_nx[FY_HI:FY_LO] = data[FINE_W-1:0];
      stage_nx[CY_HI:CY_LO] = data[DATA_W-1:FINE_W];
    end
    if (kind.addr_wr && !phase) begin
      stage_nx[TOP_BIT-1:DATA_W] = data[HI_BYTE_W-1:0];
      stage_nx[TOP_BIT]          = 1'b0;
    end
    if (kind.addr_wr && phase)
      stage_nx[DATA_W-1:0] = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_nx;
  end
endmodule

// File: rtl/scroll_phase_reg.sv
module scroll_phase_reg
  import scroll_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic [DATA_W-1:0] data,
  output logic              phase_q,
  output logic [FINE_W-1:0] fine_q,
  output logic              stb_q
);
  logic              phase_nx, phase_en;
  logic [FINE_W-1:0] fine_nx;
  logic              fine_en, stb_nx;

  always_comb begin
    phase_en = kind.stat_rd | kind.scrl_wr | kind.addr_wr;
    phase_nx = kind.stat_rd ? 1'b0 : ~phase_q;
    fine_en  = kind.scrl_wr & ~phase_q;
    fine_nx  = data[FINE_W-1:0];
    stb_nx   = kind.addr_wr & phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      fine_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      if (phase_en) phase_q <= phase_nx;
      if (fine_en)  fine_q  <= fine_nx;
      stb_q <= stb_nx;
    end
  end
endmodule

// File: rtl/scroll_latch_port.sv
module scroll_latch_port
  import scroll_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_data,
  output logic [ADDR_W-1:0] stage_addr,
  output logic [FINE_W-1:0] fine_x,
  output logic              phase,
  output logic              load_stb,
  output logic [ADDR_W-1:0] load_addr
);
  acc_kind_t kind;

  scroll_access_decode u_dec (
    .valid (acc_valid),
    .sel   (acc_sel),
    .write (acc_write),
    .kind  (kind)
  );

  scroll_stage_reg u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .phase   (phase),
    .data    (acc_data),
    .stage_q (stage_addr)
  );

  scroll_phase_reg u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .data    (acc_data),
    .phase_q (phase),
    .fine_q  (fine_x),
    .stb_q   (load_stb)
  );

  assign load_addr = stage_addr;
endmodule

// File: rtl/scroll_latch_chk.sv
module scroll_latch_chk
  import scroll_latch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [SEL_W-1:0]  acc_sel,
  input logic              acc_write,
  input logic [DATA_W-1:0] acc_data,
  input logic [ADDR_W-1:0] stage_addr,
  input logic [FINE_W-1:0] fine_x,
  input logic              phase,
  input logic              load_stb,
  input logic [ADDR_W-1:0] load_addr
);
  logic wr_ctrl, rd_stat, wr_scrl, wr_addr;
  assign wr_ctrl = acc_valid && acc_write && acc_sel == PORT_CTRL;
  assign rd_stat = acc_valid && !acc_write && acc_sel == PORT_STAT;
  assign wr_scrl = acc_valid && acc_write && acc_sel == PORT_SCRL;
  assign wr_addr = acc_valid && acc_write && acc_sel == PORT_ADDR;

  // R2
  ctrl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> stage_addr[NT_HI:NT_LO] == $past(acc_data[1:0])
            && stage_addr[CY_HI:0] == $past(stage_addr[CY_HI:0])
            && stage_addr[FY_HI:FY_LO] == $past(stage_addr[FY_HI:FY_LO])
            && $stable(phase));

  // R3
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> !phase && $stable(stage_addr) && $stable(fine_x));

  // R4
  scrl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_scrl && !phase) |=> phase && fine_x == $past(acc_data[2:0])
                         && stage_addr[CX_HI:CX_LO] == $past(acc_data[7:3]));

  // R5
  scrl_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_scrl && phase) |=> !phase && stage_addr[FY_HI:FY_LO] == $past(acc_data[2:0])
                        && stage_addr[CY_HI:CY_LO] == $past(acc_data[7:3]));

  // R6
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && !phase) |=> phase && !stage_addr[TOP_BIT]
                         && stage_addr[TOP_BIT-1:DATA_W] == $past(acc_data[5:0]));

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> load_addr == stage_addr && !phase);

  // R7
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb || $past(wr_addr && phase));

  // R11
  load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(wr_addr && phase));

  // R11
  fine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_scrl && !phase) |=> $stable(fine_x));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(stage_addr) && $stable(fine_x) && $stable(phase));
endmodule

bind scroll_latch_port scroll_latch_chk u_chk (.*);

// File: tb/scroll_latch_port_bench.sv
`timescale 1ns/1ps
module scroll_latch_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [1:0]  acc_sel;
  logic        acc_write;
  logic [7:0]  acc_data;
  logic [14:0] stage_addr;
  logic [2:0]  fine_x;
  logic        phase;
  logic        load_stb;
  logic [14:0] load_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [14:0] t;
    logic [2:0]  x;
    logic        w;
    logic        s;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [14:0] m_t;
  logic [2:0]  m_x;
  logic        m_w;

  always #4 clk = ~clk;

  scroll_latch_port u_scroll_latch_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
    .acc_write(acc_write), .acc_data(acc_data), .stage_addr(stage_addr),
    .fine_x(fine_x), .phase(phase), .load_stb(load_stb), .load_addr(load_addr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one access at the falling edge and queue the expected result
  task automatic acc(input logic v, input logic [1:0] sel, input logic wr, input logic [7:0] d, input string tag);
    exp_t e;
    logic s;
    @(negedge clk);
    acc_valid = v; acc_sel = sel; acc_write = wr; acc_data = d;
    s = 1'b0;
    if (v && wr) begin
      case (sel)
        2'd0: m_t[11:10] = d[1:0];
        2'd2: begin
          if (!m_w) begin m_t[4:0] = d[7:3]; m_x = d[2:0]; end
          else begin m_t[14:12] = d[2:0]; m_t[9:5] = d[7:3]; end
          m_w = ~m_w;
        end
        2'd3: begin
          if (!m_w) begin m_t[13:8] = d[5:0]; m_t[14] = 1'b0; end
          else begin m_t[7:0] = d; s = 1'b1; end
          m_w = ~m_w;
        end
        default: ;
      endcase
    end else if (v && !wr && sel == 2'd1) begin
      m_w = 1'b0;
    end
    e.t = m_t; e.x = m_x; e.w = m_w; e.s = s; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    acc(1'b0, 2'd0, 1'b0, 8'h00, tag);
  endtask

  // Monitor: compare outputs just after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, "stage_addr", 32'(stage_addr), 32'(e.t));
      check(e.tag, "fine_x", 32'(fine_x), 32'(e.x));
      check(e.tag, "phase", 32'(phase), 32'(e.w));
      check(e.tag, "load_stb", 32'(load_stb), 32'(e.s));
      if (e.s) check(e.tag, "load_addr", 32'(load_addr), 32'(e.t));
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_sel = '0; acc_write = 1'b0; acc_data = '0;
    m_t = '0; m_x = '0; m_w = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1", "stage_addr", 32'(stage_addr), 0);
    check("R1", "fine_x", 32'(fine_x), 0);
    check("R1", "phase", 32'(phase), 0);
    check("R1", "load_stb", 32'(load_stb), 0);
    @(negedge clk); rst_n = 1'b1;

    // R10 documented sequence
    acc(1, 2'd0, 1, 8'h00, "R10");
    acc(1, 2'd2, 1, 8'h7D, "R10");
    acc(1, 2'd2, 1, 8'h5E, "R10");
    acc(1, 2'd3, 1, 8'h3D, "R10");
    acc(1, 2'd3, 1, 8'hF0, "R10");
    idle("R10");
    @(negedge clk);
    check("R10", "stage_addr", 32'(stage_addr), 32'h3DF0);
    check("R10", "fine_x", 32'(fine_x), 32'h5);
    check("R10", "phase", 32'(phase), 0);

    // R2 control port, all four nametable values
    for (int i = 0; i < 4; i++) acc(1, 2'd0, 1, 8'hFC | 8'(i), "R2");
    // R4 / R5 scroll pair
    acc(1, 2'd2, 1, 8'hA3, "R4");
    acc(1, 2'd2, 1, 8'h6E, "R5");
    // R3 status read mid-pair restores first-byte behaviour
    acc(1, 2'd2, 1, 8'h11, "R4");
    acc(1, 2'd1, 0, 8'hFF, "R3");
    acc(1, 2'd2, 1, 8'hFF, "R4");
    acc(1, 2'd1, 0, 8'h00, "R3");
    // R6 force bit 14 low over a set bit 14
    acc(1, 2'd3, 1, 8'hFF, "R6");
    acc(1, 2'd3, 1, 8'h5A, "R7");
    idle("R7");
    // R9 ignored accesses
    acc(0, 2'd2, 1, 8'hFF, "R9");
    acc(1, 2'd0, 0, 8'hFF, "R9");
    acc(1, 2'd2, 0, 8'hFF, "R9");
    acc(1, 2'd3, 0, 8'hFF, "R9");
    acc(1, 2'd1, 1, 8'hFF, "R9");
    // R8 mixed-port sequence
    acc(1, 2'd3, 1, 8'h04, "R8");
    acc(1, 2'd2, 1, 8'h3E, "R8");
    acc(1, 2'd2, 1, 8'h7D, "R8");
    acc(1, 2'd3, 1, 8'hEF, "R8");
    idle("R8");
    @(negedge clk);
    check("R8", "stage_addr", 32'(stage_addr), 32'h64EF);
    // R11 back-to-back loads and scroll second byte keeps fine_x
    acc(1, 2'd2, 1, 8'h07, "R11");
    acc(1, 2'd2, 1, 8'hF8, "R11");
    acc(1, 2'd3, 1, 8'h21, "R11");
    acc(1, 2'd3, 1, 8'h08, "R11");
    acc(1, 2'd3, 1, 8'h22, "R11");
    acc(1, 2'd3, 1, 8'h09, "R11");
    idle("R11");
    idle("R11");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule